// File: doc/BRIEF.md
# Memory Pattern Delivery Sequencer

This block holds user bit patterns in a bank of byte-writable memories: a parameterised number of data pattern memories plus one idle-pattern memory. Each memory has its own window, given as a start byte address and a length in bits. On every bit-rate strobe the block sends out one bit, taken from the window of the memory that is active. Bits are read most significant first, and the address climbs from the window start.

A data pattern is started in single mode, where it plays once, or in continuous mode, where it repeats with no gap until it is halted. Whenever no data pattern is playing and the output is enabled, the idle pattern streams without a break. The switch from data to idle happens bit-exactly at the next strobe.

Host writes are locked out according to what the output is doing. A write that is locked out is dropped and raises a sticky flag. A window setting that would run past the end of the memory is refused and raises a second sticky flag. The memory size is a parameter, and every address check scales with it.

Top module: `bitpat_sequencer`

## Requirements
- R1: After reset, `bit_vld`, `err_lock` and `err_range` are 0. Every memory window starts at byte 0 and spans the whole memory (8 × MEM_BYTES bits).
- R2: A byte written to memory `wr_tgt` at `wr_addr` is stored. Targets 0 to NUM_MEM-1 are the data memories and target NUM_MEM is the idle memory. Window bit p of a memory with start S is bit 7-((8S+p) mod 8) of byte (8S+p)/8, so bytes are sent MSB first with the address increasing.
- R3: A window setting (`cfg_start`, `cfg_len`) is refused when `cfg_len` < 2 or 8·`cfg_start` + `cfg_len` > 8·MEM_BYTES. A refused setting leaves the window unchanged and sets `err_range`. The exact-fit boundary is accepted.
- R4: While the output is on and a data pattern is playing, writes to any memory are dropped. While the output is on and idle is playing, writes to the idle memory are dropped. A dropped write sets `err_lock`.
- R5: `err_lock` and `err_range` stay set until `err_clr` is asserted. A new error in the same cycle as `err_clr` wins.
- R6: While `out_en` is 0, no bit is emitted, and writes to every memory and window are accepted.
- R7: With no data pattern playing, the idle window streams continuously and wraps from its last bit to its first. It restarts from its first bit when the output turns on and each time it resumes after a data pattern.
- R8: In single mode the data window is sent once. The strobe after its last bit sends idle bit 0.
- R9: In continuous mode the data window repeats, with its first bit following its last bit at the next strobe.
- R10: `run_go` takes effect at the end of its cycle. A strobe in that same cycle still sends the current source's bit, and the next strobe sends data bit 0. `run_go` is ignored when `out_en` is 0 or `run_sel` ≥ `mem_used`.
- R11: `run_halt` during a data pattern makes the next strobe send idle bit 0. It has priority over `run_go`.
- R12: While `out_en` is 1, each strobe gives exactly one `bit_vld` pulse one cycle later, carrying the bit on `bit_out`. There is no pulse without a strobe.
- R13: Window settings follow the same lockout as memory writes, and a locked setting sets `err_lock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_en | input | 1 | Output on |
| mem_used | input | 3 | Number of data memories in use (1..NUM_MEM) |
| wr_en | input | 1 | Host byte write strobe |
| wr_tgt | input | 3 | Write target memory (NUM_MEM = idle) |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte |
| cfg_en | input | 1 | Window setting strobe |
| cfg_tgt | input | 3 | Window setting target memory |
| cfg_start | input | 8 | Window start byte address |
| cfg_len | input | 12 | Window length in bits |
| run_go | input | 1 | Start a data pattern |
| run_sel | input | 2 | Data memory to play |
| run_cont | input | 1 | 1 = continuous, 0 = single |
| run_halt | input | 1 | Stop data pattern, return to idle |
| bit_stb | input | 1 | Bit-rate strobe |
| err_clr | input | 1 | Clear both sticky flags |
| bit_out | output | 1 | Serial bit |
| bit_vld | output | 1 | Bit valid pulse |
| err_lock | output | 1 | Sticky: a write or setting was locked out |
| err_range | output | 1 | Sticky: a window setting was refused |

## Verification
On every cycle the assertions check the following:
- Valid pulses match the strobes one cycle later, and nothing is emitted while the output is off.
- No memory write reaches the store while a data pattern plays, and no idle write reaches it while the output is on.
- Every stored window stays inside the memory, and the play position never leaves its window.
- The lock flag stays set until it is cleared.

Only the bench's scenarios can show that the right bits come out in the right order. They sweep every data memory in both modes across window edges, cover the handover to idle bit 0, and confirm that dropped writes and refused windows leave the delivered stream unchanged.

// File: rtl/pds_pkg.sv
// Shared types for the pattern delivery sequencer.
package pds_pkg;
    // Which source the sequencer reads from.
    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_IDLE = 2'd1,
        SRC_DATA = 2'd2
    } src_t;
endpackage

// File: rtl/pds_store.sv
// Pattern store: NUM_MEM data memories plus one idle memory, each MEM_BYTES
// bytes. One byte write port and one asynchronous byte read port.
// Assumes: write permission has already been decided by the caller; cells
// carry no reset and must be written before they are delivered.
module pds_store #(
    parameter int NUM_MEM   = 4,
    parameter int MEM_BYTES = 256
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [TGT_W-1:0]         wr_tgt,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [TGT_W-1:0]         rd_tgt,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_byte
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int TGT_W  = $clog2(NUM_MEM + 1);

    logic [7:0] rd_bank [NUM_MEM+1];

    for (genvar g = 0; g <= NUM_MEM; g++) begin : g_mem
        logic [7:0] cells [MEM_BYTES];

        // Byte write into this memory when targeted.
        always_ff @(posedge clk) begin
            if (we && (wr_tgt == TGT_W'(g))) begin
                cells[wr_addr] <= wr_data;
            end
        end

        assign rd_bank[g] = cells[rd_addr];
    end

    // Select the byte of the memory being delivered.
    always_comb begin
        rd_byte = 8'h00;
        if (rd_tgt <= TGT_W'(NUM_MEM)) begin
            rd_byte = rd_bank[rd_tgt];
        end
    end
endmodule

// File: rtl/pds_cfg.sv
// Window settings: a start byte and a bit length per memory, with the range
// check that keeps every window inside the memory.
// Assumes: cfg_we already carries the lockout decision.
module pds_cfg #(
    parameter int NUM_MEM   = 4,
    parameter int MEM_BYTES = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [TGT_W-1:0]              cfg_tgt,
    input  logic [ADDR_W-1:0]             cfg_start,
    input  logic [LEN_W-1:0]              cfg_len,
    input  logic                          err_clr,
    output logic [NUM_MEM:0][ADDR_W-1:0]  win_start,
    output logic [NUM_MEM:0][LEN_W-1:0]   win_len,
    output logic                          err_range
);
    localparam int ADDR_W   = $clog2(MEM_BYTES);
    localparam int TGT_W    = $clog2(NUM_MEM + 1);
    localparam int MAX_BITS = MEM_BYTES * 8;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);

    logic [LEN_W:0] span;
    logic           fits;

    // Window end in bits and the accept decision.
    always_comb begin
        span = (LEN_W+1)'({cfg_start, 3'b000}) + (LEN_W+1)'(cfg_len);
        fits = (cfg_len >= LEN_W'(2)) && (span <= (LEN_W+1)'(MAX_BITS));
    end

    for (genvar g = 0; g <= NUM_MEM; g++) begin : g_win
        // Hold the window of memory g; update only on an accepted setting.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_start[g] <= '0;
                win_len[g]   <= LEN_W'(MAX_BITS);
            end else if (cfg_we && fits && (cfg_tgt == TGT_W'(g))) begin
                win_start[g] <= cfg_start;
                win_len[g]   <= cfg_len;
            end
        end
    end

    // Sticky refusal flag; a new refusal beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_range <= 1'b0;
        end else if (cfg_we && !fits) begin
            err_range <= 1'b1;
        end else if (err_clr) begin
            err_range <= 1'b0;
        end
    end
endmodule

// File: rtl/pds_gate.sv
// Access gate: decides whether a host byte write or window setting may go
// through, given the output state, and keeps the sticky lockout flag.
// Assumes: target NUM_MEM is the idle memory; larger targets are invalid.
module pds_gate
    import pds_pkg::*;
#(
    parameter int NUM_MEM = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  src_t             src,
    input  logic             wr_en,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic             cfg_en,
    input  logic [TGT_W-1:0] cfg_tgt,
    input  logic             err_clr,
    output logic             store_we,
    output logic             cfg_we,
    output logic             err_lock
);
    localparam int TGT_W = $clog2(NUM_MEM + 1);

    logic wr_ok, cfg_ok, denied;

    // Permission rule shared by byte writes and window settings.
    function automatic logic permit(input logic [TGT_W-1:0] tgt,
                                    input logic on, input src_t s);
        logic valid, is_idle;
        valid   = (tgt <= TGT_W'(NUM_MEM));
        is_idle = (tgt == TGT_W'(NUM_MEM));
        return valid && (!on || ((s != SRC_DATA) && !is_idle));
    endfunction

    // Gate the strobes and note any dropped access.
    always_comb begin
        wr_ok    = permit(wr_tgt, out_en, src);
        cfg_ok   = permit(cfg_tgt, out_en, src);
        store_we = wr_en && wr_ok;
        cfg_we   = cfg_en && cfg_ok;
        denied   = (wr_en && !wr_ok) || (cfg_en && !cfg_ok);
    end

    // Sticky lockout flag; a new denial beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_lock <= 1'b0;
        end else if (denied) begin
            err_lock <= 1'b1;
        end else if (err_clr) begin
            err_lock <= 1'b0;
        end
    end
endmodule

// File: rtl/pds_seq.sv
// Bit sequencer: tracks the active source and bit position, forms the read
// address of the current bit and emits one registered bit per strobe.
// Assumes: the active window is stable while it is being delivered (the
// access gate guarantees this) and its length is at least 2.
module pds_seq
    import pds_pkg::*;
#(
    parameter int NUM_MEM   = 4,
    parameter int MEM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic              bit_stb,
    input  logic              run_go,
    input  logic [SEL_W-1:0]  run_sel,
    input  logic              run_cont,
    input  logic              run_halt,
    input  logic [CNT_W-1:0]  mem_used,
    input  logic [ADDR_W-1:0] cur_start,
    input  logic [LEN_W-1:0]  cur_len,
    input  logic [7:0]        rd_byte,
    output logic [TGT_W-1:0]  rd_tgt,
    output logic [ADDR_W-1:0] rd_addr,
    output src_t              src,
    output logic [LEN_W-1:0]  pos,
    output logic              bit_out,
    output logic              bit_vld
);
    localparam int ADDR_W   = $clog2(MEM_BYTES);
    localparam int TGT_W    = $clog2(NUM_MEM + 1);
    localparam int CNT_W    = $clog2(NUM_MEM + 1);
    localparam int SEL_W    = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;
    localparam int MAX_BITS = MEM_BYTES * 8;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);
    localparam int BA_W     = ADDR_W + 3;

    src_t             src_q;
    logic [SEL_W-1:0] sel_q;
    logic [LEN_W-1:0] pos_q;
    logic             cont_q;
    logic [BA_W-1:0]  bit_addr;
    logic             cur_bit, last_bit, go_ok, halt_ok;

    assign src = src_q;
    assign pos = pos_q;

    // Address of the current bit and the control decisions.
    always_comb begin
        rd_tgt   = (src_q == SRC_DATA) ? TGT_W'(sel_q) : TGT_W'(NUM_MEM);
        bit_addr = BA_W'({cur_start, 3'b000}) + BA_W'(pos_q);
        rd_addr  = bit_addr[BA_W-1:3];
        cur_bit  = rd_byte[3'd7 - bit_addr[2:0]];
        last_bit = (pos_q == (cur_len - LEN_W'(1)));
        go_ok    = run_go && (CNT_W'(run_sel) < mem_used);
        halt_ok  = run_halt && (src_q == SRC_DATA);
    end

    // Emit one registered bit for each strobe while the output is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_vld <= 1'b0;
            bit_out <= 1'b0;
        end else begin
            bit_vld <= out_en && bit_stb;
            if (out_en && bit_stb) begin
                bit_out <= cur_bit;
            end
        end
    end

    // Source and position: off, halt, go, then strobe advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_OFF;
            sel_q  <= '0;
            pos_q  <= '0;
            cont_q <= 1'b0;
        end else if (!out_en) begin
            src_q <= SRC_OFF;
            pos_q <= '0;
        end else if (halt_ok) begin
            src_q <= SRC_IDLE;
            pos_q <= '0;
        end else if (go_ok) begin
            src_q  <= SRC_DATA;
            sel_q  <= run_sel;
            cont_q <= run_cont;
            pos_q  <= '0;
        end else if (bit_stb) begin
            if ((src_q == SRC_DATA) && last_bit && !cont_q) begin
                src_q <= SRC_IDLE;
                pos_q <= '0;
            end else begin
                src_q <= (src_q == SRC_DATA) ? SRC_DATA : SRC_IDLE;
                pos_q <= last_bit ? '0 : pos_q + LEN_W'(1);
            end
        end else if (src_q == SRC_OFF) begin
            src_q <= SRC_IDLE;
        end
    end
endmodule

// File: rtl/bitpat_sequencer.sv
// Top of the pattern delivery sequencer: joins the access gate, window
// settings, pattern store and bit sequencer.
// Assumes: MEM_BYTES is a power of two of at least 2; mem_used is 1..NUM_MEM.
module bitpat_sequencer
    import pds_pkg::*;
#(
    parameter int NUM_MEM   = 4,
    parameter int MEM_BYTES = 256,
    localparam int ADDR_W   = $clog2(MEM_BYTES),
    localparam int TGT_W    = $clog2(NUM_MEM + 1),
    localparam int CNT_W    = $clog2(NUM_MEM + 1),
    localparam int SEL_W    = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1,
    localparam int LEN_W    = $clog2(MEM_BYTES * 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic [CNT_W-1:0]  mem_used,
    input  logic              wr_en,
    input  logic [TGT_W-1:0]  wr_tgt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cfg_en,
    input  logic [TGT_W-1:0]  cfg_tgt,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              run_go,
    input  logic [SEL_W-1:0]  run_sel,
    input  logic              run_cont,
    input  logic              run_halt,
    input  logic              bit_stb,
    input  logic              err_clr,
    output logic              bit_out,
    output logic              bit_vld,
    output logic              err_lock,
    output logic              err_range
);
    src_t                         src;
    logic [LEN_W-1:0]             pos;
    logic                         store_we, cfg_we;
    logic [NUM_MEM:0][ADDR_W-1:0] win_start;
    logic [NUM_MEM:0][LEN_W-1:0]  win_len;
    logic [TGT_W-1:0]             rd_tgt;
    logic [ADDR_W-1:0]            rd_addr;
    logic [7:0]                   rd_byte;
    logic [ADDR_W-1:0]            cur_start;
    logic [LEN_W-1:0]             cur_len;

    // Window of the memory being delivered.
    always_comb begin
        cur_start = win_start[rd_tgt];
        cur_len   = win_len[rd_tgt];
    end

    pds_gate #(.NUM_MEM(NUM_MEM)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_en   (out_en),
        .src      (src),
        .wr_en    (wr_en),
        .wr_tgt   (wr_tgt),
        .cfg_en   (cfg_en),
        .cfg_tgt  (cfg_tgt),
        .err_clr  (err_clr),
        .store_we (store_we),
        .cfg_we   (cfg_we),
        .err_lock (err_lock)
    );

    pds_cfg #(.NUM_MEM(NUM_MEM), .MEM_BYTES(MEM_BYTES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_tgt   (cfg_tgt),
        .cfg_start (cfg_start),
        .cfg_len   (cfg_len),
        .err_clr   (err_clr),
        .win_start (win_start),
        .win_len   (win_len),
        .err_range (err_range)
    );

    pds_store #(.NUM_MEM(NUM_MEM), .MEM_BYTES(MEM_BYTES)) u_store (
        .clk     (clk),
        .we      (store_we),
        .wr_tgt  (wr_tgt),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_tgt  (rd_tgt),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    pds_seq #(.NUM_MEM(NUM_MEM), .MEM_BYTES(MEM_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en),
        .bit_stb   (bit_stb),
        .run_go    (run_go),
        .run_sel   (run_sel),
        .run_cont  (run_cont),
        .run_halt  (run_halt),
        .mem_used  (mem_used),
        .cur_start (cur_start),
        .cur_len   (cur_len),
        .rd_byte   (rd_byte),
        .rd_tgt    (rd_tgt),
        .rd_addr   (rd_addr),
        .src       (src),
        .pos       (pos),
        .bit_out   (bit_out),
        .bit_vld   (bit_vld)
    );
endmodule

// File: rtl/pds_checker.sv
// Checker for the pattern delivery sequencer, bound into the top module.
// Assumes: the bound signals keep the names they have in the top module.
module pds_checker
    import pds_pkg::*;
#(
    parameter int NUM_MEM   = 4,
    parameter int MEM_BYTES = 256,
    localparam int ADDR_W   = $clog2(MEM_BYTES),
    localparam int TGT_W    = $clog2(NUM_MEM + 1),
    localparam int MAX_BITS = MEM_BYTES * 8,
    localparam int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         out_en,
    input logic                         bit_stb,
    input logic                         bit_vld,
    input logic                         err_lock,
    input logic                         err_clr,
    input logic                         store_we,
    input logic [TGT_W-1:0]             wr_tgt,
    input src_t                         src,
    input logic [LEN_W-1:0]             pos,
    input logic [LEN_W-1:0]             cur_len,
    input logic [NUM_MEM:0][ADDR_W-1:0] win_start,
    input logic [NUM_MEM:0][LEN_W-1:0]  win_len
);
    // A strobe with the output on yields a valid pulse next cycle (R12).
    p_strobe_gives_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && out_en) |=> bit_vld);

    // No valid pulse without a strobe (R12).
    p_no_spurious_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> !bit_vld);

    // Output off means silence (R6).
    p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !bit_vld);

    // Lock flag is sticky until cleared (R5).
    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_lock && !err_clr) |=> err_lock);

    // No store write while a data pattern plays (R4).
    p_no_write_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we && out_en) |-> (src != SRC_DATA));

    // No idle-memory write while the output is on (R4).
    p_idle_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we && out_en) |-> (wr_tgt != TGT_W'(NUM_MEM)));

    // Play position stays inside the active window (R9).
    p_pos_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_OFF) |-> (pos < cur_len));

    for (genvar g = 0; g <= NUM_MEM; g++) begin : g_chk
        logic [LEN_W:0] span_g;
        assign span_g = (LEN_W+1)'({win_start[g], 3'b000}) + (LEN_W+1)'(win_len[g]);
        // Every stored window fits the memory (R3).
        p_window_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (win_len[g] >= LEN_W'(2)) && (span_g <= (LEN_W+1)'(MAX_BITS)));
    end
endmodule

bind bitpat_sequencer pds_checker #(.NUM_MEM(NUM_MEM), .MEM_BYTES(MEM_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_en    (out_en),
    .bit_stb   (bit_stb),
    .bit_vld   (bit_vld),
    .err_lock  (err_lock),
    .err_clr   (err_clr),
    .store_we  (store_we),
    .wr_tgt    (wr_tgt),
    .src       (src),
    .pos       (pos),
    .cur_len   (cur_len),
    .win_start (win_start),
    .win_len   (win_len)
);

// File: tb/sim_bitpat_sequencer.sv
// Bench: small configuration (4 data memories of 8 bytes), sweeping every
// memory through its window in both modes against an arithmetic model.
module sim_bitpat_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NM  = 4;
    localparam int MB  = 8;
    localparam int MAXB = MB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic out_en = 1'b0;
    logic [2:0] mem_used = 3'd4;
    logic wr_en = 1'b0;
    logic [2:0] wr_tgt = '0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic cfg_en = 1'b0;
    logic [2:0] cfg_tgt = '0;
    logic [2:0] cfg_start = '0;
    logic [6:0] cfg_len = '0;
    logic run_go = 1'b0;
    logic [1:0] run_sel = '0;
    logic run_cont = 1'b0;
    logic run_halt = 1'b0;
    logic bit_stb = 1'b0;
    logic err_clr = 1'b0;
    logic bit_out, bit_vld, err_lock, err_range;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mdl [NM+1][MB];
    int mstart [NM+1];
    int mlen [NM+1];
    int bsrc = 0;
    int bsel = 0;
    int bpos = 0;
    int bcont = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitpat_sequencer #(.NUM_MEM(NM), .MEM_BYTES(MB)) u0 (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .mem_used(mem_used),
        .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_en(cfg_en), .cfg_tgt(cfg_tgt), .cfg_start(cfg_start), .cfg_len(cfg_len),
        .run_go(run_go), .run_sel(run_sel), .run_cont(run_cont), .run_halt(run_halt),
        .bit_stb(bit_stb), .err_clr(err_clr), .bit_out(bit_out), .bit_vld(bit_vld),
        .err_lock(err_lock), .err_range(err_range)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_bit(input int m, input int p);
        int ba;
        ba = mstart[m] * 8 + p;
        return int'(mdl[m][ba / 8][7 - (ba % 8)]);
    endfunction

    // Model one strobe: expected bit, then advance.
    function automatic int model_step();
        int e;
        if (bsrc == 1) begin
            e = exp_bit(bsel, bpos);
            if (bpos == mlen[bsel] - 1) begin
                if (bcont != 0) bpos = 0;
                else begin bsrc = 0; bpos = 0; end
            end else bpos++;
        end else begin
            e = exp_bit(NM, bpos);
            bpos = (bpos == mlen[NM] - 1) ? 0 : bpos + 1;
        end
        return e;
    endfunction

    task automatic strobe(input string tag);
        int e;
        e = model_step();
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        check(bit_vld == 1'b1, tag, int'(bit_vld), 1);
        check(bit_out == e[0], tag, int'(bit_out), e);
    endtask

    task automatic host_wr(input int t, input int a, input int d, input bit ok);
        wr_en = 1'b1; wr_tgt = 3'(t); wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (ok) mdl[t][a] = 8'(d);
    endtask

    task automatic host_cfg(input int t, input int s, input int l, input bit ok);
        cfg_en = 1'b1; cfg_tgt = 3'(t); cfg_start = 3'(s); cfg_len = 7'(l);
        @(negedge clk);
        cfg_en = 1'b0;
        if (ok) begin mstart[t] = s; mlen[t] = l; end
    endtask

    task automatic clear_errs();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic go(input int s, input int c);
        run_go = 1'b1; run_sel = 2'(s); run_cont = c[0];
        @(negedge clk);
        run_go = 1'b0;
        if (out_en && (s < int'(mem_used))) begin
            bsrc = 1; bsel = s; bpos = 0; bcont = c;
        end
    endtask

    task automatic halt();
        run_halt = 1'b1;
        @(negedge clk);
        run_halt = 1'b0;
        if (bsrc == 1) begin bsrc = 0; bpos = 0; end
    endtask

    task automatic set_out(input bit on);
        out_en = on;
        @(negedge clk);
        if (on) begin bsrc = 0; bpos = 0; end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int m = 0; m <= NM; m++) begin
            mstart[m] = 0; mlen[m] = MAXB;
            for (int a = 0; a < MB; a++) mdl[m][a] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs and flags
        check(bit_vld == 1'b0, "R1", int'(bit_vld), 0);
        check(err_lock == 1'b0, "R1", int'(err_lock), 0);
        check(err_range == 1'b0, "R1", int'(err_range), 0);

        // R6: output off, every memory writable
        for (int m = 0; m <= NM; m++)
            for (int a = 0; a < MB; a++)
                host_wr(m, a, (m * 53 + a * 29 + 7) & 255, 1'b1);
        check(err_lock == 1'b0, "R6", int'(err_lock), 0);
        for (int i = 0; i < 3; i++) begin
            bit_stb = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            check(bit_vld == 1'b0, "R6", int'(bit_vld), 0);
        end

        // R1 / R2 / R7: default idle window is the whole memory, wrapping
        set_out(1'b1);
        for (int i = 0; i < MAXB + 6; i++) strobe("R1");
        // R12: no pulse without a strobe
        @(negedge clk);
        check(bit_vld == 1'b0, "R12", int'(bit_vld), 0);

        // R3: windows, accepted and refused
        set_out(1'b0);
        host_cfg(NM, 5, 13, 1'b1);
        host_cfg(0, 0, 64, 1'b1);
        host_cfg(1, 7, 8, 1'b1);
        host_cfg(2, 3, 2, 1'b1);
        host_cfg(3, 2, 30, 1'b1);
        check(err_range == 1'b0, "R3", int'(err_range), 0);
        host_cfg(1, 7, 9, 1'b0);
        @(negedge clk);
        check(err_range == 1'b1, "R3", int'(err_range), 1);
        check(err_range == 1'b1, "R5", int'(err_range), 1);
        clear_errs();
        check(err_range == 1'b0, "R5", int'(err_range), 0);
        host_cfg(2, 0, 1, 1'b0);
        check(err_range == 1'b1, "R3", int'(err_range), 1);
        clear_errs();
        host_cfg(0, 1, 64, 1'b0);
        check(err_range == 1'b1, "R3", int'(err_range), 1);
        clear_errs();

        // R7: idle window 5/13 wraps
        set_out(1'b1);
        for (int i = 0; i < 30; i++) strobe("R7");

        // R8: single mode on every memory, then idle bit 0
        for (int m = 0; m < NM; m++) begin
            go(m, 0);
            for (int i = 0; i < mlen[m] + 5; i++) strobe("R8");
        end
        // R9 / R11: continuous mode then halt
        for (int m = 0; m < NM; m++) begin
            go(m, 1);
            for (int i = 0; i < 2 * mlen[m] + 3; i++) strobe("R9");
            halt();
            for (int i = 0; i < 4; i++) strobe("R11");
        end

        // R4 / R13: lockout during data delivery
        go(3, 1);
        for (int i = 0; i < 5; i++) strobe("R4");
        host_wr(1, 2, 8'hAA, 1'b0);
        check(err_lock == 1'b1, "R4", int'(err_lock), 1);
        clear_errs();
        check(err_lock == 1'b0, "R5", int'(err_lock), 0);
        host_cfg(2, 0, 4, 1'b0);
        check(err_lock == 1'b1, "R13", int'(err_lock), 1);
        clear_errs();
        for (int i = 0; i < 5; i++) strobe("R4");
        halt();
        // R4: idle memory locked while idle plays, data memory open
        host_wr(NM, 5, 8'hFF, 1'b0);
        check(err_lock == 1'b1, "R4", int'(err_lock), 1);
        clear_errs();
        host_cfg(NM, 0, 8, 1'b0);
        check(err_lock == 1'b1, "R13", int'(err_lock), 1);
        clear_errs();
        host_wr(1, 6, 8'h5A, 1'b1);
        host_cfg(1, 6, 10, 1'b1);
        check(err_lock == 1'b0, "R4", int'(err_lock), 0);
        for (int i = 0; i < 15; i++) strobe("R4");
        go(1, 0);
        for (int i = 0; i < mlen[1] + 3; i++) strobe("R2");
        go(2, 0);
        for (int i = 0; i < mlen[2] + 3; i++) strobe("R4");

        // R10: selection beyond mem_used is ignored
        mem_used = 3'd2;
        go(3, 1);
        for (int i = 0; i < 6; i++) strobe("R10");
        go(1, 0);
        for (int i = 0; i < mlen[1] + 2; i++) strobe("R10");
        mem_used = 3'd4;
        // R10: go while off is ignored
        set_out(1'b0);
        go(0, 1);
        set_out(1'b1);
        for (int i = 0; i < 5; i++) strobe("R10");
        // R10: go and strobe in the same cycle
        begin
            int e;
            e = model_step();
            run_go = 1'b1; run_sel = 2'd3; run_cont = 1'b0; bit_stb = 1'b1;
            @(negedge clk);
            run_go = 1'b0; bit_stb = 1'b0;
            bsrc = 1; bsel = 3; bpos = 0; bcont = 0;
            check(bit_out == e[0], "R10", int'(bit_out), e);
            for (int i = 0; i < mlen[3] + 2; i++) strobe("R10");
        end
        // R11: halt beats go in the same cycle
        go(0, 1);
        strobe("R11");
        run_halt = 1'b1; run_go = 1'b1; run_sel = 2'd2;
        @(negedge clk);
        run_halt = 1'b0; run_go = 1'b0;
        bsrc = 0; bpos = 0;
        for (int i = 0; i < 4; i++) strobe("R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule